// File: doc/BRIEF.md
# Pseudo-Random Bit Sequence Generator and Checker

This block is a line-side diagnostic pattern engine. A transmit side produces a parallel word of a pseudo-random bit sequence on every enabled clock, and a receive side checks an incoming word stream against the same kind of sequence. The two sides are enabled, set up and inverted independently, so the block serves both for loopback tests and for checking a far end. A test can corrupt the transmitted stream on purpose, one bit or one whole word at a time. A corruption is inserted either once per request or on every word while a hold input is high.

The checker hunts for the pattern by loading received bits into its history. Once enough consecutive bits obey the recurrence, it declares lock and runs from its own history. From then on, every received bit that disagrees with the prediction is an error. Heavy error density drops lock and the hunt starts again. Mismatched bits are summed in a 32-bit saturating counter that is cleared when the checker is switched on. The counter is read as two 16-bit halves: a snapshot strobe copies the low half into a shadow, so the upper and lower halves belong to the same value.

Top module: `prbs_diag`

## Requirements
- R1: With tx_en high, every clock edge loads tx_data with the next W bits of the selected sequence, earliest bit in bit W-1. The sequence obeys b[n] = b[n-N] ^ b[n-M], and its history is all ones after reset. The pattern code selects the polynomial: 0 = x^31+x^28+1, 1 = x^23+x^18+1, 2 = x^15+x^14+1, 3 = x^7+x^6+1. With tx_en low, tx_data is 0 and the sequence does not advance.
- R2: With tx_invert high, every pattern bit of tx_data is inverted.
- R3: With rx_en high and the receive code and inversion matching the incoming stream, rx_sync rises only after at least 32 consecutive error-free bits. While rx_en is low, rx_sync is 0.
- R4: A receive inversion that differs from the stream's never produces lock. When both sides are inverted, the checker locks and counts no errors.
- R5: While locked, 8 or more mismatched bits within one 32-bit window (two words at W = 16) clear rx_sync on the edge that processes the word completing the count.
- R6: While locked, the counter grows by exactly the number of mismatched bits in each received word, and a clean stream adds nothing.
- R7: A rising edge on inj_bit_once flips bit 0 of exactly one transmitted word, however long the input stays high. If tx_en is low, the request waits and is applied to the next transmitted word.
- R8: A rising edge on inj_word_once inverts all bits of exactly one transmitted word. Word corruption takes precedence over bit corruption.
- R9: Every word transmitted while inj_bit_hold is high has bit 0 flipped.
- R10: Every word transmitted while inj_word_hold is high is fully inverted.
- R11: A rising edge of rx_en clears the counter. err_cnt_hi shows bits 31:16 of the live count. A cnt_snap pulse copies bits 15:0 of the same count into err_cnt_lo on the next edge.
- R12: rx_err is high for one cycle after each locked word that contained at least one mismatched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit pattern enable |
| tx_poly | input | 2 | Transmit polynomial code |
| tx_invert | input | 1 | Invert transmitted pattern |
| inj_bit_once | input | 1 | Single-bit error request (edge) |
| inj_word_once | input | 1 | Whole-word error request (edge) |
| inj_bit_hold | input | 1 | Continuous single-bit errors while high |
| inj_word_hold | input | 1 | Continuous whole-word errors while high |
| tx_data | output | W | Transmitted pattern word |
| rx_en | input | 1 | Checker enable; rising edge clears the counter |
| rx_poly | input | 2 | Receive polynomial code |
| rx_invert | input | 1 | Receive stream is inverted |
| rx_data | input | W | Received word |
| rx_sync | output | 1 | Checker locked |
| rx_err | output | 1 | Last locked word had errors |
| cnt_snap | input | 1 | Capture low half of the counter |
| err_cnt_hi | output | 16 | Live upper half of the error count |
| err_cnt_lo | output | 16 | Captured lower half of the error count |

## Verification
A transmitted word, including any requested corruption, appears at tx_data one edge after the edge that samples tx_en and the injection inputs. The bench compares it one nanosecond after that edge against its own model of the sequence. The receive input is looped back from tx_data, so the checker's status and counter update one edge later still, and err_cnt_lo follows cnt_snap by one edge. The bench therefore reads rx_sync and the counter only after several settling words, and checks sync timing with a margin on each side of the 32-bit acquisition rule rather than at one exact edge.

// File: rtl/prbs_diag_pkg.sv
package prbs_diag_pkg;

  localparam int HIST_W = 31;

  typedef enum logic [1:0] {
    POLY31 = 2'd0,
    POLY23 = 2'd1,
    POLY15 = 2'd2,
    POLY7  = 2'd3
  } poly_t;

  typedef enum logic {
    CHK_HUNT = 1'b0,
    CHK_LOCK = 1'b1
  } chk_state_t;

  // Degree of the polynomial: distance of the far tap.
  function automatic logic [4:0] tap_far(poly_t p);
    case (p)
      POLY31:  return 5'd31;
      POLY23:  return 5'd23;
      POLY15:  return 5'd15;
      default: return 5'd7;
    endcase
  endfunction

  // Distance of the near tap.
  function automatic logic [4:0] tap_near(poly_t p);
    case (p)
      POLY31:  return 5'd28;
      POLY23:  return 5'd18;
      POLY15:  return 5'd14;
      default: return 5'd6;
    endcase
  endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_diag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  poly_t        sel,
  input  logic         inv,
  input  logic         bit_once,
  input  logic         word_once,
  input  logic         bit_hold,
  input  logic         word_hold,
  output logic [W-1:0] data_o
);

  logic [HIST_W-1:0] hist_q, hist_n;
  logic [W-1:0]      pat, mask, data_n;
  logic [W-1:0]      data_q;
  logic              bit_prev_q, word_prev_q;
  logic              pend_bit_q, pend_word_q;
  logic              pend_bit_n, pend_word_n;
  logic              fire_bit, fire_word;

  // Pattern expansion: W steps of the recurrence, earliest bit at W-1.
  always_comb begin
    logic [HIST_W-1:0] h;
    logic [4:0]        tf, tn;
    logic              nb;
    h  = hist_q;
    tf = tap_far(sel);
    tn = tap_near(sel);
    pat = '0;
    for (int i = W - 1; i >= 0; i--) begin
      nb     = h[tf - 5'd1] ^ h[tn - 5'd1];
      pat[i] = nb;
      h      = {h[HIST_W-2:0], nb};
    end
    hist_n = h;
  end

  // Injection: one-shot requests act on their rising edge and wait for tx.
  always_comb begin
    fire_bit    = (bit_once & ~bit_prev_q) | pend_bit_q;
    fire_word   = (word_once & ~word_prev_q) | pend_word_q;
    if (word_hold || fire_word) begin
      mask = '1;
    end else if (bit_hold || fire_bit) begin
      mask = W'(1);
    end else begin
      mask = '0;
    end
    data_n      = en ? (pat ^ {W{inv}} ^ mask) : '0;
    pend_bit_n  = en ? 1'b0 : fire_bit;
    pend_word_n = en ? 1'b0 : fire_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
    end else if (en) begin
      hist_q <= hist_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= '0;
      bit_prev_q  <= 1'b0;
      word_prev_q <= 1'b0;
      pend_bit_q  <= 1'b0;
      pend_word_q <= 1'b0;
    end else begin
      data_q      <= data_n;
      bit_prev_q  <= bit_once;
      word_prev_q <= word_once;
      pend_bit_q  <= pend_bit_n;
      pend_word_q <= pend_word_n;
    end
  end

  assign data_o = data_q;

  // R1: idle transmitter drives zero and its history stays put
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (data_o == '0));
  a_r1_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hist_q));
  // R7: pending one-shot requests are consumed by a transmitted word
  a_r7_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (!pend_bit_q && !pend_word_q));

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_diag_pkg::*;
#(
  parameter int W        = 16,
  parameter int ACQ_BITS = 32,
  parameter int WIN_BITS = 32,
  parameter int LOS_ERRS = 8,
  localparam int CW        = $clog2(W + 1),
  localparam int RUN_W     = $clog2(ACQ_BITS + W + 1),
  localparam int WE_W      = $clog2(LOS_ERRS + W + 1),
  localparam int WIN_WORDS = (WIN_BITS / W > 0) ? (WIN_BITS / W) : 1,
  localparam int WIX_W     = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  poly_t         sel,
  input  logic          inv,
  input  logic [W-1:0]  data_i,
  output logic          sync_o,
  output logic          err_o,
  output logic [CW-1:0] cnt_inc
);

  chk_state_t        state_q, state_n;
  logic [HIST_W-1:0] hist_q, hist_n;
  logic [RUN_W-1:0]  run_q, run_n, run_inc;
  logic [WIX_W-1:0]  widx_q, widx_n;
  logic [WE_W-1:0]   werr_q, werr_n, wsum;
  logic [CW-1:0]     errs;
  logic              err_n;

  // Prediction: hunting loads received bits, lock runs on predictions.
  always_comb begin
    logic [HIST_W-1:0] h;
    logic [W-1:0]      d, e;
    logic [4:0]        tf, tn;
    logic              pred;
    d  = data_i ^ {W{inv}};
    h  = hist_q;
    tf = tap_far(sel);
    tn = tap_near(sel);
    e  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      pred = h[tf - 5'd1] ^ h[tn - 5'd1];
      e[i] = d[i] ^ pred;
      h    = {h[HIST_W-2:0], (state_q == CHK_LOCK) ? pred : d[i]};
    end
    hist_n = h;
    errs   = '0;
    for (int i = 0; i < W; i++) begin
      errs = errs + CW'(e[i]);
    end
  end

  // Lock state machine.
  always_comb begin
    state_n = state_q;
    run_n   = run_q;
    widx_n  = widx_q;
    werr_n  = werr_q;
    run_inc = run_q + RUN_W'(W);
    wsum    = werr_q + WE_W'(errs);
    if (!en) begin
      state_n = CHK_HUNT;
      run_n   = '0;
      widx_n  = '0;
      werr_n  = '0;
    end else if (state_q == CHK_HUNT) begin
      if (errs == '0) begin
        if (run_inc >= RUN_W'(ACQ_BITS)) begin
          state_n = CHK_LOCK;
          run_n   = '0;
          widx_n  = '0;
          werr_n  = '0;
        end else begin
          run_n = run_inc;
        end
      end else begin
        run_n = '0;
      end
    end else begin
      if (wsum >= WE_W'(LOS_ERRS)) begin
        state_n = CHK_HUNT;
        run_n   = '0;
        widx_n  = '0;
        werr_n  = '0;
      end else if (widx_q == WIX_W'(WIN_WORDS - 1)) begin
        widx_n = '0;
        werr_n = '0;
      end else begin
        widx_n = widx_q + WIX_W'(1);
        werr_n = wsum;
      end
    end
    err_n   = en && (state_q == CHK_LOCK) && (errs != '0);
    cnt_inc = (en && (state_q == CHK_LOCK)) ? errs : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
    end else if (en) begin
      hist_q <= hist_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CHK_HUNT;
      run_q   <= '0;
      widx_q  <= '0;
      werr_q  <= '0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_n;
      run_q   <= run_n;
      widx_q  <= widx_n;
      werr_q  <= werr_n;
      err_o   <= err_n;
    end
  end

  assign sync_o = (state_q == CHK_LOCK);

  // R3: disabled checker is never locked; lock follows a clean word
  a_r3_off_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sync_o);
  a_r3_lock_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> ($past(en) && $past(errs == '0)));
  // R5: dense errors inside a window drop lock
  a_r5_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sync_o && (wsum >= WE_W'(LOS_ERRS))) |=> !sync_o);
  // R12: error flag only reports words seen while locked
  a_r12_flag_locked: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(sync_o));

endmodule

// File: rtl/err_acc.sv
module err_acc #(
  parameter int HALF  = 16,
  parameter int INC_W = 5,
  localparam int CNT_W = 2 * HALF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  input  logic             snap,
  output logic [HALF-1:0]  hi_o,
  output logic [HALF-1:0]  lo_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   sum;
  logic [HALF-1:0]  lo_q, lo_n;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
    if (clr) begin
      cnt_n = '0;
      lo_n  = '0;
    end else begin
      cnt_n = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      lo_n  = snap ? cnt_q[HALF-1:0] : lo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lo_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      lo_q  <= lo_n;
    end
  end

  assign hi_o = cnt_q[CNT_W-1:HALF];
  assign lo_o = lo_q;

  // R11: clear and snapshot behaviour
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  a_r11_snap_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !clr) |=> (lo_o == $past(cnt_q[HALF-1:0])));
  // R6: the count never falls and holds at its ceiling
  a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_q == '1)) |=> (cnt_q == '1));

endmodule

// File: rtl/prbs_diag.sv
module prbs_diag
  import prbs_diag_pkg::*;
#(
  parameter int W        = 16,
  parameter int ACQ_BITS = 32,
  parameter int WIN_BITS = 32,
  parameter int LOS_ERRS = 8,
  localparam int HALF = 16,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic [1:0]      tx_poly,
  input  logic            tx_invert,
  input  logic            inj_bit_once,
  input  logic            inj_word_once,
  input  logic            inj_bit_hold,
  input  logic            inj_word_hold,
  output logic [W-1:0]    tx_data,
  input  logic            rx_en,
  input  logic [1:0]      rx_poly,
  input  logic            rx_invert,
  input  logic [W-1:0]    rx_data,
  output logic            rx_sync,
  output logic            rx_err,
  input  logic            cnt_snap,
  output logic [HALF-1:0] err_cnt_hi,
  output logic [HALF-1:0] err_cnt_lo
);

  logic [1:0]    rs_q;
  logic          rst_n_s;
  logic          rx_en_prev_q;
  logic          cnt_clr;
  logic [CW-1:0] cnt_inc;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rx_en_prev_q <= 1'b0;
    end else begin
      rx_en_prev_q <= rx_en;
    end
  end
  assign cnt_clr = rx_en & ~rx_en_prev_q;

  prbs_gen #(.W(W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (tx_en),
    .sel       (poly_t'(tx_poly)),
    .inv       (tx_invert),
    .bit_once  (inj_bit_once),
    .word_once (inj_word_once),
    .bit_hold  (inj_bit_hold),
    .word_hold (inj_word_hold),
    .data_o    (tx_data)
  );

  prbs_chk #(
    .W        (W),
    .ACQ_BITS (ACQ_BITS),
    .WIN_BITS (WIN_BITS),
    .LOS_ERRS (LOS_ERRS)
  ) u_chk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (rx_en),
    .sel     (poly_t'(rx_poly)),
    .inv     (rx_invert),
    .data_i  (rx_data),
    .sync_o  (rx_sync),
    .err_o   (rx_err),
    .cnt_inc (cnt_inc)
  );

  err_acc #(.HALF(HALF), .INC_W(CW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .snap  (cnt_snap),
    .hi_o  (err_cnt_hi),
    .lo_o  (err_cnt_lo)
  );

endmodule

// File: tb/sim_prbs_diag.sv
`timescale 1ns/1ps
module sim_prbs_diag;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_en = 1'b0;
  logic [1:0]   tx_poly = 2'd0;
  logic         tx_invert = 1'b0;
  logic         inj_bit_once = 1'b0;
  logic         inj_word_once = 1'b0;
  logic         inj_bit_hold = 1'b0;
  logic         inj_word_hold = 1'b0;
  logic [W-1:0] tx_data;
  logic         rx_en = 1'b0;
  logic [1:0]   rx_poly = 2'd0;
  logic         rx_invert = 1'b0;
  logic         rx_sync, rx_err;
  logic         cnt_snap = 1'b0;
  logic [15:0]  err_cnt_hi, err_cnt_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [30:0]  m_hist = '1;
  logic [W-1:0] nxt_mask = '0;
  bit           chk_tx = 1'b0;
  string        tx_req = "R1";
  int           err_pulses = 0;
  longint       exp_cnt = 0;

  always #2 clk = ~clk;

  prbs_diag #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_poly(tx_poly),
    .tx_invert(tx_invert), .inj_bit_once(inj_bit_once),
    .inj_word_once(inj_word_once), .inj_bit_hold(inj_bit_hold),
    .inj_word_hold(inj_word_hold), .tx_data(tx_data), .rx_en(rx_en),
    .rx_poly(rx_poly), .rx_invert(rx_invert), .rx_data(tx_data),
    .rx_sync(rx_sync), .rx_err(rx_err), .cnt_snap(cnt_snap),
    .err_cnt_hi(err_cnt_hi), .err_cnt_lo(err_cnt_lo)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference sequence: b[n] = b[n-deg] ^ b[n-near], most recent in bit 0.
  function automatic logic [W-1:0] model_word(input int code);
    int deg, near;
    logic [W-1:0] w;
    logic b;
    case (code)
      0: begin deg = 31; near = 28; end
      1: begin deg = 23; near = 18; end
      2: begin deg = 15; near = 14; end
      default: begin deg = 7; near = 6; end
    endcase
    for (int k = 0; k < W; k++) begin
      b = m_hist[deg-1] ^ m_hist[near-1];
      w[W-1-k] = b;
      m_hist = {m_hist[29:0], b};
    end
    return w;
  endfunction

  task automatic cyc();
    logic [W-1:0] e;
    @(posedge clk);
    if (tx_en) e = model_word(int'(tx_poly)) ^ {W{tx_invert}} ^ nxt_mask;
    else e = '0;
    #1;
    if (chk_tx) check(tx_data == e, tx_req, tx_data, e);
    if (rx_err) err_pulses++;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic read_cnt(output longint v);
    logic [15:0] hi;
    hi = err_cnt_hi;
    cnt_snap = 1'b1;
    cyc();
    cnt_snap = 1'b0;
    v = {hi, err_cnt_lo};
  endtask

  task automatic restart_rx();
    rx_en = 1'b0;
    cyc();
    rx_en = 1'b1;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    longint v;
    int k;
    void'($urandom(32'd61357));

    // Reset state
    repeat (3) @(posedge clk);
    #1;
    check(tx_data == '0, "R1 reset tx", tx_data, 0);
    check(rx_sync == 1'b0, "R3 reset sync", rx_sync, 0);
    check({err_cnt_hi, err_cnt_lo} == 32'd0, "R11 reset count", {err_cnt_hi, err_cnt_lo}, 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: each polynomial, random order, checked word by word
    chk_tx = 1'b1;
    tx_en = 1'b1;
    tx_req = "R1 pattern";
    for (int p = 0; p < 6; p++) begin
      tx_poly = 2'($urandom_range(0, 3));
      wait_cyc(12);
    end
    tx_en = 1'b0;
    tx_req = "R1 idle";
    wait_cyc(3);
    tx_en = 1'b1;
    tx_req = "R1 resume";
    wait_cyc(5);

    // R2: inverted transmit
    tx_invert = 1'b1;
    tx_req = "R2 invert";
    wait_cyc(10);
    tx_invert = 1'b0;

    // R3: acquisition
    tx_poly = 2'($urandom_range(0, 3));
    rx_poly = tx_poly;
    rx_invert = 1'b0;
    tx_req = "R1 during R3";
    rx_en = 1'b1;
    cyc();
    cyc();
    check(rx_sync == 1'b0, "R3 no lock before 32 bits", rx_sync, 0);
    wait_cyc(10);
    check(rx_sync == 1'b1, "R3 lock on clean stream", rx_sync, 1);
    read_cnt(v);
    check(v == 0, "R6 clean stream count", v, 0);
    exp_cnt = 0;

    // R7 and R12: one-shot bit request held for four cycles
    err_pulses = 0;
    tx_req = "R7 bit once";
    inj_bit_once = 1'b1;
    nxt_mask = W'(1);
    cyc();
    nxt_mask = '0;
    wait_cyc(3);
    inj_bit_once = 1'b0;
    wait_cyc(4);
    exp_cnt += 1;
    read_cnt(v);
    check(v == exp_cnt, "R7 one error counted", v, exp_cnt);
    check(err_pulses == 1, "R12 one flag pulse", err_pulses, 1);
    check(rx_sync == 1'b1, "R5 lock kept at one error", rx_sync, 1);

    // R7: request while idle waits for next word
    tx_en = 1'b0;
    inj_bit_once = 1'b1;
    tx_req = "R7 pending";
    cyc();
    inj_bit_once = 1'b0;
    cyc();
    tx_en = 1'b1;
    nxt_mask = W'(1);
    cyc();
    nxt_mask = '0;
    wait_cyc(12);
    check(rx_sync == 1'b1, "R7 relock after idle gap", rx_sync, 1);
    restart_rx();
    wait_cyc(10);
    exp_cnt = 0;

    // R9: continuous single-bit errors for a random number of words
    k = $urandom_range(2, 6);
    tx_req = "R9 bit hold";
    inj_bit_hold = 1'b1;
    nxt_mask = W'(1);
    wait_cyc(k);
    inj_bit_hold = 1'b0;
    nxt_mask = '0;
    wait_cyc(4);
    exp_cnt += k;
    read_cnt(v);
    check(v == exp_cnt, "R9 R6 hold count", v, exp_cnt);
    check(rx_sync == 1'b1, "R9 lock kept", rx_sync, 1);

    // R8 and R5: one whole-word error drops lock
    tx_req = "R8 word once";
    inj_word_once = 1'b1;
    inj_bit_once = 1'b1;
    nxt_mask = '1;
    cyc();
    inj_word_once = 1'b0;
    inj_bit_once = 1'b0;
    nxt_mask = '0;
    cyc();
    check(rx_sync == 1'b0, "R5 lock lost on word error", rx_sync, 0);
    wait_cyc(10);
    check(rx_sync == 1'b1, "R8 relock", rx_sync, 1);
    exp_cnt += W;
    read_cnt(v);
    check(v == exp_cnt, "R8 R6 word error count", v, exp_cnt);

    // R10: continuous word errors
    tx_req = "R10 word hold";
    inj_word_hold = 1'b1;
    nxt_mask = '1;
    wait_cyc(3);
    inj_word_hold = 1'b0;
    nxt_mask = '0;
    check(rx_sync == 1'b0, "R10 lock lost", rx_sync, 0);
    wait_cyc(12);
    check(rx_sync == 1'b1, "R10 relock", rx_sync, 1);
    exp_cnt += W;
    read_cnt(v);
    check(v == exp_cnt, "R10 count of first word", v, exp_cnt);

    // R4: inversion mismatch, then both inverted
    tx_req = "R2 during R4";
    rx_invert = 1'b1;
    restart_rx();
    read_cnt(v);
    check(v == 0, "R11 cleared on enable", v, 0);
    wait_cyc(15);
    check(rx_sync == 1'b0, "R4 no lock on mismatch", rx_sync, 0);
    tx_invert = 1'b1;
    wait_cyc(10);
    check(rx_sync == 1'b1, "R4 lock both inverted", rx_sync, 1);
    read_cnt(v);
    check(v == 0, "R4 no errors inverted", v, 0);

    // R11: count past 16 bits, split read
    restart_rx();
    wait_cyc(10);
    tx_req = "R9 long hold";
    inj_bit_hold = 1'b1;
    nxt_mask = W'(1);
    wait_cyc(65540);
    inj_bit_hold = 1'b0;
    nxt_mask = '0;
    wait_cyc(4);
    check(err_cnt_hi == 16'd1, "R11 high half", err_cnt_hi, 1);
    read_cnt(v);
    check(v == 65540, "R11 coherent split value", v, 65540);
    check(err_cnt_lo == 16'd4, "R11 low half", err_cnt_lo, 4);

    finish_run();
  end

endmodule